// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes waiting in a transmit FIFO into asynchronous serial frames on a single output line. The frame shape is chosen at run time through a handful of configuration inputs: the number of data bits (one to eight), whether a parity bit follows the data and which sense it has, whether one or two stop bits close the frame, whether a clear-to-send input must permit each new frame, and a break override that holds the line low.

Timing comes from an external oversampling strobe that pulses at sixteen times the bit rate; the block counts those strobes and never generates a baud rate itself. When it is idle and the FIFO holds data, it pops one byte with a single-cycle strobe and captures the whole frame configuration, so settings changed during a frame take effect from the next frame.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line output `txd` is high, `fifo_pop` is low and `busy` is low.
- R2: `fifo_pop` is a single-cycle strobe, raised only while the block is idle and `fifo_empty` is low; the byte on `fifo_data` in that cycle is the one sent, and `busy` is high from the next cycle.
- R3: A frame opens with one low start bit, followed by `cfg_wlen`+1 data bits taken from `fifo_data` least significant bit first (`cfg_wlen` = 7 gives eight bits).
- R4: Every bit of the frame (start, data, parity, stop) lasts exactly 16 cycles in which `tick16` is high.
- R5: When `cfg_par_en` is 1, one parity bit follows the last data bit; with `cfg_par_even` = 1 it is the XOR of the sent data bits (even count of ones including parity), with `cfg_par_even` = 0 it is the complement of that XOR.
- R6: The frame ends with one high stop bit when `cfg_two_stop` = 0 and two when it is 1; the cycle after the last stop bit ends, `busy` is low and `txd` is high, and a waiting byte is popped at once.
- R7: With `cfg_hs_en` = 1, no byte is popped and no frame starts while `cts` is low; a frame already under way completes in full if `cts` falls.
- R8: While `cfg_force_brk` is 1, `txd` is low whatever the frame state, and the frame sequence and its timing continue unchanged underneath.
- R9: Word length, parity enable, parity sense and stop-bit count are captured at the pop; changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling strobe, 16 per bit time |
| cfg_wlen | input | 3 | Data bits minus one |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| cfg_hs_en | input | 1 | Require `cts` high to start a frame |
| cfg_force_brk | input | 1 | Hold `txd` low |
| cts | input | 1 | Clear-to-send, active high |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_pop | output | 1 | One-cycle pop strobe |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is in progress |

## Verification
The frame check is swept across all 64 combinations of word length, parity enable, parity sense and stop count, each with two data bytes of differing bit weight, so a wrong bit order, a dropped or extra data bit, a flipped parity sense or a missing second stop bit each shows as a mismatch at a known bit slot. The oversampling strobe is high only one cycle in three, which separates counting strobes from counting clock cycles, and every cycle of every bit is compared so a short or long bit is caught. Separate runs hold `cts` low with data waiting, drop `cts` and scramble the configuration just after a pop, and hold the break override across a whole frame, telling apart gating at the frame start from gating mid-frame and output forcing from state changes.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [2:0] {
      TXS_IDLE  = 3'd0,
      TXS_START = 3'd1,
      TXS_DATA  = 3'd2,
      TXS_PAR   = 3'd3,
      TXS_STOP  = 3'd4
   } txs_e;

endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
   parameter int DW = 8,
   parameter int LW = 3
) (
   input  logic [DW-1:0] data,
   input  logic [LW-1:0] wlen,
   input  logic          even,
   output logic          par
);

   logic [DW-1:0] used;

   for (genvar i = 0; i < DW; i++) begin : g_mask
      assign used[i] = data[i] & (LW'(i) <= wlen);
   end

   assign par = even ? (^used) : ~(^used);

endmodule

// File: rtl/uart_tx_bittimer.sv
module uart_tx_bittimer #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  logic tick,
   output logic bit_end
);

   localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);

   logic [CW-1:0] cnt;

   assign bit_end = run && tick && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear || bit_end) begin
         cnt <= '0;
      end else if (run && tick) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R4
   cnt_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt == '0));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
   parameter int DATA_MAX = 8,
   parameter int OVS      = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick16,
   input  logic [$clog2(DATA_MAX)-1:0]  cfg_wlen,
   input  logic                         cfg_par_en,
   input  logic                         cfg_par_even,
   input  logic                         cfg_two_stop,
   input  logic                         cfg_hs_en,
   input  logic                         cfg_force_brk,
   input  logic                         cts,
   input  logic                         fifo_empty,
   input  logic [DATA_MAX-1:0]          fifo_data,
   output logic                         fifo_pop,
   output logic                         txd,
   output logic                         busy
);
   import uart_tx_pkg::*;

   localparam int LEN_W = $clog2(DATA_MAX);

   initial begin
      assert (DATA_MAX >= 2 && (1 << LEN_W) == DATA_MAX)
         else $error("DATA_MAX must be a power of two, at least 2");
      assert (OVS >= 2) else $error("OVS must be at least 2");
   end

   txs_e                state_q;
   logic [DATA_MAX-1:0] shreg_q;
   logic [LEN_W-1:0]    bitidx_q;
   logic [LEN_W-1:0]    wlen_q;
   logic                par_en_q;
   logic                two_stop_q;
   logic                par_bit_q;
   logic                stopidx_q;
   logic                line_q;
   logic                start_ok;
   logic                bit_end;
   logic                par_calc;

   assign start_ok = (state_q == TXS_IDLE) && !fifo_empty && (!cfg_hs_en || cts);
   assign fifo_pop = start_ok;
   assign busy     = (state_q != TXS_IDLE);
   assign txd      = cfg_force_brk ? 1'b0 : line_q;

   uart_tx_parity #(.DW(DATA_MAX), .LW(LEN_W)) u_par (
      .data (fifo_data),
      .wlen (cfg_wlen),
      .even (cfg_par_even),
      .par  (par_calc)
   );

   uart_tx_bittimer #(.OVS(OVS)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start_ok),
      .run     (busy),
      .tick    (tick16),
      .bit_end (bit_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= TXS_IDLE;
         shreg_q    <= '0;
         bitidx_q   <= '0;
         wlen_q     <= '0;
         par_en_q   <= 1'b0;
         two_stop_q <= 1'b0;
         par_bit_q  <= 1'b0;
         stopidx_q  <= 1'b0;
         line_q     <= 1'b1;
      end else if (start_ok) begin
         state_q    <= TXS_START;
         shreg_q    <= fifo_data;
         wlen_q     <= cfg_wlen;
         par_en_q   <= cfg_par_en;
         two_stop_q <= cfg_two_stop;
         par_bit_q  <= par_calc;
         line_q     <= 1'b0;
      end else if (bit_end) begin
         unique case (state_q)
            TXS_START: begin
               state_q  <= TXS_DATA;
               bitidx_q <= '0;
               line_q   <= shreg_q[0];
               shreg_q  <= shreg_q >> 1;
            end
            TXS_DATA: begin
               if (bitidx_q == wlen_q) begin
                  if (par_en_q) begin
                     state_q <= TXS_PAR;
                     line_q  <= par_bit_q;
                  end else begin
                     state_q   <= TXS_STOP;
                     stopidx_q <= 1'b0;
                     line_q    <= 1'b1;
                  end
               end else begin
                  bitidx_q <= bitidx_q + 1'b1;
                  line_q   <= shreg_q[0];
                  shreg_q  <= shreg_q >> 1;
               end
            end
            TXS_PAR: begin
               state_q   <= TXS_STOP;
               stopidx_q <= 1'b0;
               line_q    <= 1'b1;
            end
            TXS_STOP: begin
               if (stopidx_q == two_stop_q) begin
                  state_q <= TXS_IDLE;
               end else begin
                  stopidx_q <= 1'b1;
               end
               line_q <= 1'b1;
            end
            default: begin
               state_q <= TXS_IDLE;
               line_q  <= 1'b1;
            end
         endcase
      end
   end

   // R2
   pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> (busy && !fifo_pop));

   // R7
   hs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hs_en && !cts) |-> !fifo_pop);

   // R3
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> !line_q);

   // R6
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cfg_force_brk) |-> txd);

   // R8
   brk_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_force_brk |-> !txd);

endmodule

// File: tb/sim_uart_frame_tx.sv
`timescale 1ns/100ps
module sim_uart_frame_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic [2:0] cfg_wlen = 3'd7;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_even = 1'b0;
   logic       cfg_two_stop = 1'b0;
   logic       cfg_hs_en = 1'b0;
   logic       cfg_force_brk = 1'b0;
   logic       cts = 1'b0;
   logic       fifo_empty = 1'b1;
   logic [7:0] fifo_data = 8'h00;
   logic       fifo_pop;
   logic       txd;
   logic       busy;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   uart_frame_tx #(.DATA_MAX(8), .OVS(16)) u0 (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg_wlen(cfg_wlen),
      .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
      .cfg_two_stop(cfg_two_stop), .cfg_hs_en(cfg_hs_en),
      .cfg_force_brk(cfg_force_brk), .cts(cts), .fifo_empty(fifo_empty),
      .fifo_data(fifo_data), .fifo_pop(fifo_pop), .txd(txd), .busy(busy)
   );

   always #2 clk = ~clk;

   initial begin : tick_gen
      int ph;
      ph = 0;
      forever begin
         @(posedge clk);
         #1;
         ph = (ph + 1) % 3;
         tick16 = (ph == 0);
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // Sends byte d; expectations are taken from the configuration at call time.
   // scramble flips every frame setting and drops cts right after the pop.
   task automatic run_frame(input logic [7:0] d, input bit scramble, input string req);
      logic exp_b [0:15];
      int   nb;
      int   ones;
      bit   got_pop;
      bit   bad;
      int   t;
      logic brk;
      logic [2:0] w;
      logic pe, pv, ts;
      w = cfg_wlen; pe = cfg_par_en; pv = cfg_par_even; ts = cfg_two_stop;
      brk = cfg_force_brk;
      nb = 0; ones = 0;
      exp_b[nb] = 1'b0; nb++;
      for (int i = 0; i <= int'(w); i++) begin
         exp_b[nb] = d[i]; nb++;
         ones += d[i];
      end
      if (pe) begin
         exp_b[nb] = pv ? logic'(ones % 2) : logic'(1 - ones % 2); nb++;
      end
      exp_b[nb] = 1'b1; nb++;
      if (ts) begin
         exp_b[nb] = 1'b1; nb++;
      end
      if (brk) for (int i = 0; i < nb; i++) exp_b[i] = 1'b0;

      @(posedge clk); #1;
      fifo_data  = d;
      fifo_empty = 1'b0;
      got_pop = 0;
      for (int k = 0; k < 100 && !got_pop; k++) begin
         @(negedge clk);
         if (fifo_pop) got_pop = 1;
      end
      check(got_pop, "R2", int'(got_pop), 1);
      @(posedge clk); #1;
      fifo_empty = 1'b1;
      fifo_data  = ~d;
      if (scramble) begin
         cfg_wlen = ~cfg_wlen; cfg_par_en = ~cfg_par_en;
         cfg_par_even = ~cfg_par_even; cfg_two_stop = ~cfg_two_stop;
         cts = 1'b0;
      end
      for (int b = 0; b < nb; b++) begin
         bad = 0; t = 0;
         while (t < 16) begin
            @(negedge clk);
            if (txd !== exp_b[b]) bad = 1;
            if (tick16) t++;
         end
         check(!bad, req, int'(txd), int'(exp_b[b]));
      end
      @(negedge clk);
      check(busy == 1'b0, "R6", int'(busy), 0);
      check(txd == !brk, "R6", int'(txd), int'(!brk));
      if (scramble) begin
         cfg_wlen = w; cfg_par_en = pe; cfg_par_even = pv; cfg_two_stop = ts;
      end
   endtask

   initial begin : watchdog
      #(4 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end

   initial begin : stim
      bit seen;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(txd == 1'b1, "R1", int'(txd), 1);
      check(fifo_pop == 1'b0, "R1", int'(fifo_pop), 0);
      check(busy == 1'b0, "R1", int'(busy), 0);
      @(posedge clk); #1 rst_n = 1'b1;

      // R2: empty FIFO never popped
      seen = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (fifo_pop || busy) seen = 1;
      end
      check(!seen, "R2", int'(seen), 0);

      // R3 R4 R5 R6: sweep all frame formats
      for (int c = 0; c < 64; c++) begin
         cfg_wlen = c[2:0]; cfg_par_en = c[3]; cfg_par_even = c[4]; cfg_two_stop = c[5];
         run_frame(8'((c * 37 + 11) ^ 8'hA5), 0, "R3 R4 R5 R6 frame");
         run_frame(8'(c * 73 + 200), 0, "R3 R4 R5 R6 frame");
      end

      // R7: handshake holds the frame back
      cfg_wlen = 3'd7; cfg_par_en = 1'b1; cfg_par_even = 1'b0; cfg_two_stop = 1'b1;
      cfg_hs_en = 1'b1; cts = 1'b0;
      @(posedge clk); #1 fifo_empty = 1'b0; fifo_data = 8'h3C;
      seen = 0;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (fifo_pop || busy || !txd) seen = 1;
      end
      check(!seen, "R7 blocked", int'(seen), 0);
      @(posedge clk); #1 fifo_empty = 1'b1;
      cts = 1'b1;
      // R7 R9: cts drops and settings change mid-frame
      run_frame(8'h96, 1, "R7 R9 frame");
      cts = 1'b1;
      cfg_wlen = 3'd4; cfg_par_en = 1'b1; cfg_par_even = 1'b1; cfg_two_stop = 1'b0;
      run_frame(8'h1B, 1, "R9 frame");
      cfg_hs_en = 1'b0;

      // R8: break override at idle and during a frame
      @(posedge clk); #1 cfg_force_brk = 1'b1;
      @(negedge clk);
      check(txd == 1'b0, "R8", int'(txd), 0);
      cfg_wlen = 3'd7; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
      run_frame(8'hFF, 0, "R8 frame");
      @(posedge clk); #1 cfg_force_brk = 1'b0;
      @(negedge clk);
      check(txd == 1'b1, "R8", int'(txd), 1);
      run_frame(8'h55, 0, "R8 after release");

      summary();
   end

endmodule